// File: doc/BRIEF.md
# SHA-1 Hash Accelerator with Sequenced Host Access

The block computes the SHA-1 compression function over 512-bit message blocks. The host first writes the sixteen 32-bit words of an already padded block, then writes a control word whose start bit launches the engine. A five-state sequencer performs the launch. From idle it moves to a block-capture state, then to a state that hands the control word to the core, then waits for the core to finish, and finally writes the 160-bit result into read-only digest registers. The core runs one round per clock, 80 rounds per block, and keeps a rolling 16-word message schedule.

Every word is reached through a Wishbone-style slave. A second debug probe port can also write any register and read any register back combinationally. A probe-enable input decides which of the two ports owns writes. A message longer than one block is hashed by starting each further block with the init bit clear. The engine then chains from the digest registers.

Top module: `sha1_accel_top`

## Requirements
- R1: Word offsets 0 to 15 hold the message block, with word 0 first in message order. Each is writable and reads back the last accepted value.
- R2: A Wishbone access raises the acknowledge in the cycle after cyc and stb are first seen high. The acknowledge lasts exactly one cycle, and read data is valid while it is high.
- R3: Writing offset 16 with bit0 (start) set and bit1 (init) set hashes the block from the standard initial vector. For the padded message "abc", offsets 18 to 22 read a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d, with the first word at offset 18.
- R4: A start with init clear chains from the current digest registers. The padded two-block 56-character test message yields 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1, and arbitrary blocks match a reference model.
- R5: Status at offset 17 has bit0 ready set only while the sequencer is idle. After a start, ready drops until the digest is written. When the run completes, the start bit in the control readback is cleared and the init bit is kept.
- R6: Status bit1 (digest valid) is cleared when a start is accepted. It is set when the digest is written and stays set until the next start. A control write with start clear does not change it.
- R7: A control write while the sequencer is not idle is ignored.
- R8: Status and digest offsets ignore writes. Offsets 23 and above read as zero.
- R9: With probe enable high, probe writes take effect and Wishbone writes are acknowledged but discarded. With probe enable low, probe writes are discarded. The probe read port returns the addressed register in the same cycle.
- R10: A synchronous active-high reset makes the sequencer idle and clears block, control, status and digest registers, including during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | ADDR_W | Bus word address |
| wb_dat_i | input | 32 | Bus write data |
| wb_dat_o | output | 32 | Bus read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| probe_en_i | input | 1 | Probe port owns writes |
| probe_we_i | input | 1 | Probe write strobe |
| probe_adr_i | input | ADDR_W | Probe word address |
| probe_wdat_i | input | 32 | Probe write data |
| probe_rdat_o | output | 32 | Probe combinational read data |

## Verification
Two situations are hard to reach from the ports. One is a control write that arrives while a run is in flight. The other is a reset that lands in the middle of the 80 rounds. The bench reaches the first by issuing a second control write right after the launching one, before the sequencer returns to idle. It then reads the control word back to see that the write was discarded. It reaches the second by raising reset a few cycles after a start, then reading every register class back. Chaining is exercised with the two-block test message and with a pseudo-random block run after a prior digest, so the chaining value is a non-trivial state.

// File: rtl/sha1_acc_pkg.sv
package sha1_acc_pkg;
   localparam int WORD_W    = 32;
   localparam int BLK_WORDS = 16;
   localparam int DIG_WORDS = 5;
   localparam int BLK_W     = WORD_W * BLK_WORDS;
   localparam int DIG_W     = WORD_W * DIG_WORDS;
   localparam int NROUNDS   = 80;
   localparam int PHASE_LEN = 20;
   localparam int OFF_CTRL  = 16;
   localparam int OFF_STAT  = 17;
   localparam int OFF_DIG   = 18;
   localparam int NMAP      = OFF_DIG + DIG_WORDS;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [DIG_W-1:0]  digest_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_READ_IN,
      SQ_WRITE_CTRL,
      SQ_WAIT_COMPUTE,
      SQ_WRITE_OUT
   } seq_state_t;

   localparam digest_t INIT_VEC = {32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                   32'h10325476, 32'hc3d2e1f0};

   function automatic word_t rotl(input word_t x, input int unsigned n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   function automatic word_t mix_f(input logic [1:0] ph, input word_t b,
                                   input word_t c, input word_t d);
      case (ph)
         2'd0:    return (b & c) | (~b & d);
         2'd2:    return (b & c) | (b & d) | (c & d);
         default: return b ^ c ^ d;
      endcase
   endfunction

   function automatic word_t mix_k(input logic [1:0] ph);
      case (ph)
         2'd0:    return 32'h5a827999;
         2'd1:    return 32'h6ed9eba1;
         2'd2:    return 32'h8f1bbcdc;
         default: return 32'hca62c1d6;
      endcase
   endfunction
endpackage

// File: rtl/sha1_round_engine.sv
module sha1_round_engine
   import sha1_acc_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             go_i,
   input  digest_t          base_i,
   input  logic [BLK_W-1:0] block_i,
   output logic             ready_o,
   output logic             done_o,
   output digest_t          hash_o
);
   localparam int CNT_W = $clog2(NROUNDS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NROUNDS - 1);

   word_t            win_q   [BLK_WORDS];
   word_t            win_nxt [BLK_WORDS];
   word_t            va, vb, vc, vd, ve;
   digest_t          base_q, hash_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, done_q;
   logic [1:0]       phase;
   word_t            temp, w_next;

   always_comb begin
      phase  = 2'(int'(cnt_q) / PHASE_LEN);
      temp   = rotl(va, 5) + mix_f(phase, vb, vc, vd) + ve + mix_k(phase) + win_q[0];
      w_next = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
   end

   for (genvar i = 0; i < BLK_WORDS; i++) begin : g_sched
      if (i == BLK_WORDS - 1) begin : g_tail
         assign win_nxt[i] = w_next;
      end else begin : g_shift
         assign win_nxt[i] = win_q[i+1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= '0;
      end else if (go_i && !busy_q) begin
         for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= block_i[i*WORD_W +: WORD_W];
      end else if (busy_q) begin
         for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= win_nxt[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
         hash_q <= '0;
         {va, vb, vc, vd, ve} <= '0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !busy_q) begin
            {va, vb, vc, vd, ve} <= base_i;
            base_q <= base_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            va    <= temp;
            vb    <= va;
            vc    <= rotl(vb, 30);
            vd    <= vc;
            ve    <= vd;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               hash_q <= {base_q[159:128] + temp, base_q[127:96] + va,
                          base_q[95:64] + rotl(vb, 30), base_q[63:32] + vc,
                          base_q[31:0] + vd};
            end
         end
      end
   end

   assign ready_o = !busy_q;
   assign done_o  = done_q;
   assign hash_o  = hash_q;

   assert_go_idle_R5: assert property (@(posedge clk) disable iff (rst)
      go_i |-> !busy_q);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);
   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(done_q) |-> $past(busy_q));
endmodule

// File: rtl/sha1_sequencer.sv
module sha1_sequencer
   import sha1_acc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic core_ready_i,
   input  logic core_done_i,
   output logic go_o,
   output logic cap_o,
   output logic idle_o,
   output logic dvalid_o
);
   seq_state_t state_q, state_d;
   logic       dvalid_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE:         if (start_i) state_d = SQ_READ_IN;
         SQ_READ_IN:      if (start_i && core_ready_i) state_d = SQ_WRITE_CTRL;
         SQ_WRITE_CTRL:   state_d = SQ_WAIT_COMPUTE;
         SQ_WAIT_COMPUTE: if (core_done_i) state_d = SQ_WRITE_OUT;
         SQ_WRITE_OUT:    state_d = SQ_IDLE;
         default:         state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= SQ_IDLE;
         dvalid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && start_i) dvalid_q <= 1'b0;
         else if (state_q == SQ_WRITE_OUT)  dvalid_q <= 1'b1;
      end
   end

   assign go_o     = (state_q == SQ_WRITE_CTRL);
   assign cap_o    = (state_q == SQ_WRITE_OUT);
   assign idle_o   = (state_q == SQ_IDLE);
   assign dvalid_o = dvalid_q;

   assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_WAIT_COMPUTE && !core_done_i) |=> state_q == SQ_WAIT_COMPUTE);
   assert_readin_gate_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_READ_IN && !(start_i && core_ready_i)) |=> state_q == SQ_READ_IN);
   assert_ctrl_to_wait_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_WRITE_CTRL) |=> state_q == SQ_WAIT_COMPUTE);
   assert_out_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_WRITE_OUT) |=> (state_q == SQ_IDLE && dvalid_q));
   assert_dvalid_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (dvalid_q && !(state_q == SQ_IDLE && start_i)) |=> dvalid_q);
endmodule

// File: rtl/sha1_host_regs.sv
module sha1_host_regs
   import sha1_acc_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter bit PROBE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  word_t             wb_dat_i,
   output word_t             wb_dat_o,
   output logic              wb_ack_o,
   input  logic              probe_en_i,
   input  logic              probe_we_i,
   input  logic [ADDR_W-1:0] probe_adr_i,
   input  word_t             probe_wdat_i,
   output word_t             probe_rdat_o,
   input  logic              idle_i,
   input  logic              dvalid_i,
   input  logic              cap_i,
   input  digest_t           hash_i,
   output logic [BLK_W-1:0]  block_o,
   output logic              start_o,
   output logic              init_o,
   output digest_t           digest_o
);
   initial begin
      if (ADDR_W < $clog2(NMAP)) $fatal(1, "ADDR_W too small for register map");
   end

   word_t             blk_q [BLK_WORDS];
   word_t             map   [NMAP];
   digest_t           dig_q;
   logic              start_q, init_q, ack_q;
   word_t             dat_q, wb_rd;
   logic              wb_req, wr_en;
   logic [ADDR_W-1:0] wr_adr;
   word_t             wr_dat;

   assign wb_req = wb_cyc_i && wb_stb_i && !ack_q;

   function automatic word_t map_read(input logic [ADDR_W-1:0] a, input word_t m [NMAP]);
      word_t r = '0;
      for (int i = 0; i < NMAP; i++) if (int'(a) == i) r = m[i];
      return r;
   endfunction

   for (genvar i = 0; i < BLK_WORDS; i++) begin : g_blkmap
      assign map[i] = blk_q[i];
      assign block_o[i*WORD_W +: WORD_W] = blk_q[i];
   end
   assign map[OFF_CTRL] = {{(WORD_W-2){1'b0}}, init_q, start_q};
   assign map[OFF_STAT] = {{(WORD_W-2){1'b0}}, dvalid_i, idle_i};
   for (genvar j = 0; j < DIG_WORDS; j++) begin : g_digmap
      assign map[OFF_DIG+j] = dig_q[DIG_W-1-j*WORD_W -: WORD_W];
   end

   assign wb_rd = map_read(wb_adr_i, map);

   if (PROBE_EN) begin : g_probe
      assign wr_en        = probe_en_i ? probe_we_i : (wb_req && wb_we_i);
      assign wr_adr       = probe_en_i ? probe_adr_i : wb_adr_i;
      assign wr_dat       = probe_en_i ? probe_wdat_i : wb_dat_i;
      assign probe_rdat_o = map_read(probe_adr_i, map);
   end else begin : g_noprobe
      assign wr_en        = wb_req && wb_we_i;
      assign wr_adr       = wb_adr_i;
      assign wr_dat       = wb_dat_i;
      assign probe_rdat_o = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < BLK_WORDS; i++) blk_q[i] <= '0;
      end else if (wr_en && int'(wr_adr) < BLK_WORDS) begin
         blk_q[wr_adr[3:0]] <= wr_dat;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= 1'b0;
         init_q  <= 1'b0;
         dig_q   <= '0;
      end else begin
         if (cap_i) begin
            start_q <= 1'b0;
            dig_q   <= hash_i;
         end else if (wr_en && wr_adr == ADDR_W'(OFF_CTRL) && idle_i) begin
            start_q <= wr_dat[0];
            init_q  <= wr_dat[1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
         dat_q <= '0;
      end else begin
         ack_q <= wb_req;
         if (wb_req) dat_q <= wb_rd;
      end
   end

   assign wb_ack_o = ack_q;
   assign wb_dat_o = dat_q;
   assign start_o  = start_q;
   assign init_o   = init_q;
   assign digest_o = dig_q;

   assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      wb_ack_o |=> !wb_ack_o);
   assert_ctrl_busy_R7: assert property (@(posedge clk) disable iff (rst)
      (!idle_i && !cap_i) |=> ($stable(start_q) && $stable(init_q)));
   assert_digest_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> $stable(dig_q));
endmodule

// File: rtl/sha1_accel_top.sv
module sha1_accel_top
   import sha1_acc_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter bit PROBE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [31:0]       wb_dat_i,
   output logic [31:0]       wb_dat_o,
   output logic              wb_ack_o,
   input  logic              probe_en_i,
   input  logic              probe_we_i,
   input  logic [ADDR_W-1:0] probe_adr_i,
   input  logic [31:0]       probe_wdat_i,
   output logic [31:0]       probe_rdat_o
);
   logic [BLK_W-1:0] block;
   logic             start, init, go, cap, idle, dvalid, core_ready, core_done;
   digest_t          digest, hash, base;

   assign base = init ? INIT_VEC : digest;

   sha1_host_regs #(.ADDR_W(ADDR_W), .PROBE_EN(PROBE_EN)) u_regs (
      .clk(clk), .rst(rst),
      .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
      .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
      .probe_en_i(probe_en_i), .probe_we_i(probe_we_i), .probe_adr_i(probe_adr_i),
      .probe_wdat_i(probe_wdat_i), .probe_rdat_o(probe_rdat_o),
      .idle_i(idle), .dvalid_i(dvalid), .cap_i(cap), .hash_i(hash),
      .block_o(block), .start_o(start), .init_o(init), .digest_o(digest)
   );

   sha1_sequencer u_seq (
      .clk(clk), .rst(rst), .start_i(start), .core_ready_i(core_ready),
      .core_done_i(core_done), .go_o(go), .cap_o(cap), .idle_o(idle), .dvalid_o(dvalid)
   );

   sha1_round_engine u_core (
      .clk(clk), .rst(rst), .go_i(go), .base_i(base), .block_i(block),
      .ready_o(core_ready), .done_o(core_done), .hash_o(hash)
   );
endmodule

// File: tb/tb_sha1_accel_top.sv
module tb_sha1_accel_top;
   import sha1_acc_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
   logic [4:0]  wb_adr = '0;
   logic [31:0] wb_dat = '0;
   logic [31:0] wb_rdat;
   logic        wb_ack;
   logic        probe_en = 0, probe_we = 0;
   logic [4:0]  probe_adr = '0;
   logic [31:0] probe_wdat = '0;
   logic [31:0] probe_rdat;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic exp_ack = 1'b0;
   logic use_probe = 1'b0;

   word_t   model_blk [16];
   digest_t model_dig = '0;

   sha1_accel_top dut (
      .clk(clk), .rst(rst),
      .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
      .wb_dat_i(wb_dat), .wb_dat_o(wb_rdat), .wb_ack_o(wb_ack),
      .probe_en_i(probe_en), .probe_we_i(probe_we), .probe_adr_i(probe_adr),
      .probe_wdat_i(probe_wdat), .probe_rdat_o(probe_rdat)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2: reference acknowledge, recomputed every clock
   always @(posedge clk) exp_ack <= rst ? 1'b0 : (wb_cyc && wb_stb && !exp_ack);
   always @(negedge clk) if (!rst) chk("R2 ack timing", {31'b0, wb_ack}, {31'b0, exp_ack});

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL R5 watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic digest_t ref_sha1(input digest_t h, input word_t m [16]);
      word_t w [80];
      word_t a, b, c, d, e, f, k, t;
      for (int i = 0; i < 16; i++) w[i] = m[i];
      for (int i = 16; i < 80; i++) begin
         t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
         w[i] = {t[30:0], t[31]};
      end
      {a, b, c, d, e} = h;
      for (int i = 0; i < 80; i++) begin
         if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
         else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
         else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
         else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
         t = {a[26:0], a[31:27]} + f + e + k + w[i];
         e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
      end
      return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
   endfunction

   task automatic wb_xfer(input logic w, input int adr, input word_t d, output word_t q);
      @(negedge clk);
      wb_cyc = 1; wb_stb = 1; wb_we = w; wb_adr = 5'(adr); wb_dat = d;
      @(negedge clk);
      q = wb_rdat;
      chk("R2 ack after request", {31'b0, wb_ack}, 32'd1);
      wb_cyc = 0; wb_stb = 0; wb_we = 0;
   endtask

   task automatic wr(input int adr, input word_t d);
      word_t q;
      if (use_probe) begin
         @(negedge clk);
         probe_we = 1; probe_adr = 5'(adr); probe_wdat = d;
         @(negedge clk);
         probe_we = 0;
      end else begin
         wb_xfer(1'b1, adr, d, q);
      end
      if (adr < 16 && use_probe == probe_en) model_blk[adr] = d;
   endtask

   task automatic rd(input int adr, output word_t q);
      if (use_probe) begin
         @(negedge clk);
         probe_adr = 5'(adr);
         #1 q = probe_rdat;
      end else begin
         wb_xfer(1'b0, adr, 32'h0, q);
      end
   endtask

   task automatic load_block(input word_t b [16]);
      word_t q;
      for (int i = 0; i < 16; i++) wr(i, b[i]);
      for (int i = 0; i < 16; i++) begin
         rd(i, q);
         chk("R1 block readback", q, model_blk[i]);
      end
   endtask

   task automatic do_hash(input logic init, input string req, input logic poke);
      word_t   q;
      digest_t exp;
      int      n;
      exp = ref_sha1(init ? INIT_VEC : model_dig, model_blk);
      wr(OFF_CTRL, {30'b0, init, 1'b1});
      if (poke) wr(OFF_CTRL, {30'b0, ~init, 1'b1});
      rd(OFF_STAT, q);
      chk("R5 R6 status busy", q, 32'd0);
      rd(OFF_CTRL, q);
      chk("R7 R5 control held while busy", q, {30'b0, init, 1'b1});
      n = 0;
      q = '0;
      while (q != 32'd3 && n < 400) begin
         rd(OFF_STAT, q);
         n++;
      end
      chk("R5 R6 status done", q, 32'd3);
      rd(OFF_CTRL, q);
      chk("R5 start cleared", q, {30'b0, init, 1'b0});
      for (int j = 0; j < 5; j++) begin
         rd(OFF_DIG + j, q);
         chk(req, q, exp[159-32*j -: 32]);
      end
      model_dig = exp;
   endtask

   initial begin
      word_t   blk [16];
      word_t   q;
      digest_t known;
      for (int i = 0; i < 16; i++) model_blk[i] = '0;

      repeat (3) @(negedge clk);
      rst = 0;
      // R10 reset state
      rd(OFF_STAT, q);  chk("R10 reset status", q, 32'd1);
      rd(OFF_CTRL, q);  chk("R10 reset control", q, 32'd0);
      rd(OFF_DIG, q);   chk("R10 reset digest", q, 32'd0);

      // R3: one-block "abc"
      for (int i = 0; i < 16; i++) blk[i] = '0;
      blk[0] = 32'h61626380; blk[15] = 32'h18;
      load_block(blk);
      known = {32'ha9993e36, 32'h4706816a, 32'hba3e2571, 32'h7850c26c, 32'h9cd0d89d};
      chk("R3 reference vector", ref_sha1(INIT_VEC, model_blk)[31:0], known[31:0]);
      do_hash(1'b1, "R3 abc digest", 1'b0);

      // R6: control write without start keeps digest valid
      wr(OFF_CTRL, 32'h2);
      repeat (5) @(negedge clk);
      rd(OFF_STAT, q);  chk("R6 valid held without start", q, 32'd3);

      // R8: read-only and unmapped
      wr(OFF_DIG, 32'hdeadbeef);
      rd(OFF_DIG, q);   chk("R8 digest read-only", q, 32'ha9993e36);
      wr(OFF_STAT, 32'h0);
      rd(OFF_STAT, q);  chk("R8 status read-only", q, 32'd3);
      rd(25, q);        chk("R8 unmapped reads zero", q, 32'd0);

      // R4: two-block message, second block chained
      for (int i = 0; i < 14; i++) blk[i] = {8'(8'h61+i), 8'(8'h62+i), 8'(8'h63+i), 8'(8'h64+i)};
      blk[14] = 32'h80000000; blk[15] = 32'h0;
      load_block(blk);
      do_hash(1'b1, "R4 first block", 1'b1);
      for (int i = 0; i < 16; i++) blk[i] = '0;
      blk[15] = 32'h1c0;
      load_block(blk);
      known = {32'h84983e44, 32'h1c3bd26e, 32'hbaae4aa1, 32'hf95129e5, 32'he54670f1};
      do_hash(1'b0, "R4 two-block digest", 1'b0);
      chk("R4 known vector", model_dig[159:128], known[159:128]);

      // R4: pseudo-random chained block
      for (int i = 0; i < 16; i++) blk[i] = (32'h9e3779b9 * (i + 7)) ^ 32'h5bd1e995;
      load_block(blk);
      do_hash(1'b0, "R4 random chained digest", 1'b0);

      // R9: probe port ownership
      probe_en = 1;
      wr(3, 32'h11112222);
      use_probe = 1;
      rd(3, q);         chk("R9 wishbone write discarded", q, model_blk[3]);
      for (int i = 0; i < 16; i++) blk[i] = 32'h01020304 * (i + 1);
      load_block(blk);
      do_hash(1'b1, "R9 probe-driven digest", 1'b0);
      probe_en = 0;
      wr(5, 32'hcafef00d);
      rd(5, q);         chk("R9 probe write discarded", q, model_blk[5]);
      use_probe = 0;

      // R10: reset during a run
      wr(OFF_CTRL, 32'h3);
      repeat (10) @(negedge clk);
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      rd(OFF_STAT, q);  chk("R10 status after mid-run reset", q, 32'd1);
      rd(OFF_CTRL, q);  chk("R10 control after mid-run reset", q, 32'd0);
      rd(0, q);         chk("R10 block after mid-run reset", q, 32'd0);
      rd(OFF_DIG + 4, q); chk("R10 digest after mid-run reset", q, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule